// File: doc/BRIEF.md
# DMA interrupt status aggregator

This block holds the interrupt control and status state for thirteen DMA channels and reduces it to one level-sensitive interrupt request for the system interrupt controller. The DMA engines report each event with a one-cycle pulse: a slice finished, a whole transfer finished, or an interrupt-flagged tag finished. A separate one-cycle pulse reports a bus error. Software reaches three word registers through one write port and one combinational read port.

Register A covers channels 0 to 6, the bus-error flag, the master enable and the master flag. Register B covers channels 7 to 12 and the tag-interrupt enables. Register C is the global interrupt control. A channel flag latches only when the channel can interrupt, and software clears it by writing 1 to it. The master flag is a fixed Boolean of the stored state. A global control bit can hold the request line low without changing the master flag.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, registers A, B and C read 0 and `irq` is low.
- R2: Register A layout: bits 0-6 are the slice-mode bits of channels 0-6, bits 16-22 are their mask bits, bits 24-30 are their flags, bit 15 is the bus-error flag, bit 23 is the master enable and bit 31 is the master flag. With its mask bit set, a `xfer_done` pulse on channel 0-6 sets that channel's flag on the next cycle.
- R3: For channels 0-6, a `slice_done` pulse sets the flag only when the channel's slice-mode bit is 1 (and its mask is 1). Channels 7-12 ignore `slice_done`.
- R4: A channel whose mask bit is 0 does not latch a flag from `xfer_done` or `slice_done`. Register B bits 16-21 are the masks and bits 24-29 are the flags of channels 7-12.
- R5: Writing 1 to a flag bit, or to bus-error bit 15, clears that bit. Writing 0 leaves it unchanged. When a setting event and a clearing write arrive in the same cycle, the bit ends up set.
- R6: Register B bits 0-12 are the tag-interrupt enables. Only bits 4, 9 and 10 can be written. The other enable bits always read 0.
- R7: A `tag_irq` pulse on a channel whose tag enable is 1 sets that channel's flag whatever its mask bit is. With the tag enable at 0, the pulse has no effect.
- R8: A `bus_err` pulse sets bit 15 of register A.
- R9: Register A bit 31 equals bus-error flag OR (register C bit 0 AND master enable AND any of the 13 channel flags). With register C bit 0 at 0, only a bus error can raise it.
- R10: `irq` equals register A bit 31 while register C bit 1 is 0. `irq` is held low while register C bit 1 is 1, and bit 31 is unaffected.
- R11: Unused bits of every register read 0 and ignore writes. Register C uses only bits 0-1. Select value 3 reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slice_done | input | 13 | Per-channel slice or list-unit completion pulse |
| xfer_done | input | 13 | Per-channel whole-transfer completion pulse |
| tag_irq | input | 13 | Per-channel interrupt-tag completion pulse |
| bus_err | input | 1 | Bus error pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0=A, 1=B, 2=C |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read target: 0=A, 1=B, 2=C |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions assume that every event input is a single-cycle pulse raised by an engine that is running. They also assume that writes and events are sampled only on the rising edge and that no input is X once reset is released. The bench drives all stimulus on the falling edge and holds each pulse for exactly one cycle. It returns every event vector to zero before the next operation, so each flag change can be traced to a single event or write. The channel sweeps cover all thirteen channels one at a time. The master-flag sweep walks every combination of bus error, master enable, global enable, pending flag and output block.

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int NCH = 13,
  parameter int NLO = 7,
  parameter logic [NCH-1:0] TAG_OK = 13'h0610
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] slice_done,
  input  logic [NCH-1:0] xfer_done,
  input  logic [NCH-1:0] tag_irq,
  input  logic           bus_err,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [31:0]    wr_data,
  input  logic [1:0]     rd_sel,
  output logic [31:0]    rd_data,
  output logic           irq
);
  localparam int NHI = NCH - NLO;

  logic [NLO-1:0] mode_q;
  logic [NCH-1:0] mask_q, flag_q, tagen_q;
  logic           me_q, berr_q;
  logic [1:0]     ctl_q;

  wire wa = wr_en && (wr_sel == 2'd0);
  wire wb = wr_en && (wr_sel == 2'd1);
  wire wc = wr_en && (wr_sel == 2'd2);

  wire [NCH-1:0] mode_all = {{NHI{1'b0}}, mode_q};
  wire [NCH-1:0] flag_set = (mask_q & (xfer_done | (mode_all & slice_done)))
                          | (tagen_q & tag_irq);
  wire [NCH-1:0] flag_clr = {wb ? wr_data[24 +: NHI] : {NHI{1'b0}},
                             wa ? wr_data[24 +: NLO] : {NLO{1'b0}}};
  wire master = berr_q | (ctl_q[0] & me_q & (|flag_q));

  assign irq = master & ~ctl_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      mask_q  <= '0;
      flag_q  <= '0;
      tagen_q <= '0;
      me_q    <= 1'b0;
      berr_q  <= 1'b0;
      ctl_q   <= 2'b00;
    end else begin
      flag_q <= (flag_q & ~flag_clr) | flag_set;
      berr_q <= (berr_q & ~(wa & wr_data[15])) | bus_err;
      if (wa) begin
        mode_q          <= wr_data[NLO-1:0];
        mask_q[NLO-1:0] <= wr_data[16 +: NLO];
        me_q            <= wr_data[23];
      end
      if (wb) begin
        mask_q[NCH-1:NLO] <= wr_data[16 +: NHI];
        tagen_q           <= wr_data[NCH-1:0] & TAG_OK;
      end
      if (wc) ctl_q <= wr_data[1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      2'd0: begin
        rd_data[NLO-1:0]  = mode_q;
        rd_data[15]       = berr_q;
        rd_data[16 +: NLO] = mask_q[NLO-1:0];
        rd_data[23]       = me_q;
        rd_data[24 +: NLO] = flag_q[NLO-1:0];
        rd_data[31]       = master;
      end
      2'd1: begin
        rd_data[NCH-1:0]  = tagen_q;
        rd_data[16 +: NHI] = mask_q[NCH-1:NLO];
        rd_data[24 +: NHI] = flag_q[NCH-1:NLO];
      end
      2'd2: rd_data[1:0] = ctl_q;
      default: rd_data = '0;
    endcase
  end

  // R4 R7
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q)) &
     ~$past((mask_q & (xfer_done | (mode_all & slice_done))) | (tagen_q & tag_irq))) == '0);

  // R10
  irq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[1] |-> !irq);

  // R8
  berr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_err) && !ctl_q[1] |-> irq);

  // R5
  berr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wa && wr_data[15] && !bus_err) |-> !berr_q);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> berr_q || (me_q && ctl_q[0]));

  // R6
  tagen_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wb) |-> tagen_q == ($past(wr_data[NCH-1:0]) & TAG_OK));
endmodule

// File: tb/dma_irq_status_test.sv
module dma_irq_status_test;
  logic clk = 0, rst_n = 0;
  logic [12:0] slice_done = 0, xfer_done = 0, tag_irq = 0;
  logic bus_err = 0, wr_en = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_irq_status uut (.clk(clk), .rst_n(rst_n), .slice_done(slice_done),
    .xfer_done(xfer_done), .tag_irq(tag_irq), .bus_err(bus_err), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq));

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    step();
    wr_en = 0; wr_data = 0;
  endtask

  task automatic ev(input logic [12:0] sl, input logic [12:0] xf, input logic [12:0] tg, input logic be);
    slice_done = sl; xfer_done = xf; tag_irq = tg; bus_err = be;
    step();
    slice_done = 0; xfer_done = 0; tag_irq = 0; bus_err = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    rd_sel = s; #1; v = rd_data;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] flagbit(input int ch);
    return 32'h1 << (24 + (ch < 7 ? ch : ch - 7));
  endfunction
  function automatic logic [31:0] maskbit(input int ch);
    return 32'h1 << (16 + (ch < 7 ? ch : ch - 7));
  endfunction
  function automatic logic [1:0] regof(input int ch);
    return ch < 7 ? 2'd0 : 2'd1;
  endfunction

  initial begin
    #800000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    @(negedge clk); step(); step();
    rst_n = 1;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin rd(s[1:0], v); chk("R1", v, 0); end
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 R4 R5: mask gating, set and clear on every channel
    for (int ch = 0; ch < 13; ch++) begin
      wr(regof(ch), 0);
      ev(0, 13'h1 << ch, 0, 0);
      rd(regof(ch), v); chk("R4 masked", v & flagbit(ch), 0);
      wr(regof(ch), maskbit(ch));
      ev(0, 13'h1 << ch, 0, 0);
      rd(regof(ch), v); chk("R2 set", v, maskbit(ch) | flagbit(ch));
      wr(regof(ch), maskbit(ch));
      rd(regof(ch), v); chk("R5 hold on 0", v & flagbit(ch), flagbit(ch));
      wr(regof(ch), maskbit(ch) | flagbit(ch));
      rd(regof(ch), v); chk("R5 clear", v & flagbit(ch), 0);
      wr(regof(ch), 0);
    end

    // R3: slice events follow the mode bit
    for (int ch = 0; ch < 13; ch++) begin
      for (int m = 0; m < 2; m++) begin
        logic [31:0] cfg;
        cfg = maskbit(ch) | ((ch < 7 && m == 1) ? (32'h1 << ch) : 0);
        wr(regof(ch), cfg);
        ev(13'h1 << ch, 0, 0, 0);
        rd(regof(ch), v);
        chk("R3 slice", v & flagbit(ch), (ch < 7 && m == 1) ? flagbit(ch) : 0);
        wr(regof(ch), flagbit(ch));
      end
    end

    // R6: tag enable writability
    wr(1, 32'h0000_1FFF);
    rd(1, v); chk("R6", v, 32'h0000_0610);

    // R7: tag events bypass masks, need tag enable
    for (int ch = 0; ch < 13; ch++) begin
      ev(0, 0, 13'h1 << ch, 0);
      rd(regof(ch), v);
      chk("R7 tag", v & flagbit(ch), (ch == 4 || ch == 9 || ch == 10) ? flagbit(ch) : 0);
      wr(regof(ch), flagbit(ch) | (ch < 7 ? 0 : 32'h610));
    end
    wr(1, 0);

    // R5: set wins over simultaneous clear
    wr(0, maskbit(2));
    wr_en = 1; wr_sel = 0; wr_data = maskbit(2) | flagbit(2) | 32'h8000;
    xfer_done = 13'h4; bus_err = 1;
    step();
    wr_en = 0; xfer_done = 0; bus_err = 0;
    rd(0, v); chk("R5 set wins", v & 32'h0400_8000, 32'h0400_8000);
    wr(0, flagbit(2) | 32'h8000);
    rd(0, v); chk("R5 clear both", v, 0);

    // R8 R9 R10: master flag and output sweep
    for (int k = 0; k < 32; k++) begin
      bit be, me, en, fl, blk, mexp;
      be = k[0]; me = k[1]; en = k[2]; fl = k[3]; blk = k[4];
      wr(2, {30'b0, blk, en});
      wr(1, fl ? maskbit(12) : 0);
      wr(0, me ? 32'h0080_0000 : 0);
      if (fl) ev(0, 13'h1000, 0, 0);
      if (be) ev(0, 0, 0, 1);
      mexp = be | (en & me & fl);
      rd(0, v);
      chk("R8", {31'b0, v[15]}, {31'b0, be});
      chk("R9 master", {31'b0, v[31]}, {31'b0, mexp});
      chk("R10 irq", {31'b0, irq}, {31'b0, mexp & ~blk});
      wr(0, 32'h8000);
      wr(1, flagbit(12));
    end

    // R11: unused bits
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R11 A", v, 32'h00FF_007F);
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R11 B", v, 32'h003F_0610);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v); chk("R11 C", v, 32'h3);
    wr(3, 32'hFFFF_FFFF);
    rd(3, v); chk("R11 sel3", v, 0);
    rd(2, v); chk("R11 sel3 write", v, 32'h3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule